// File: doc/BRIEF.md
# Half-Duplex Serial ADC Controller

This block is the master side of a link to a 12-bit serial analog-to-digital converter whose command input and result output share one data pin. When a command is accepted the controller pulls chip select low, generates a serial clock by dividing the system clock, and shifts out a five-bit command. The command is a start bit of 1 followed by four configuration bits. The controller then releases the data pin part way through the fifth clock period. From then on the converter drives the line, and the controller shifts in twelve result bits.

The shared pin appears as three signals: a driven value, an output enable and a sampled input. The pad and any bus wrapper sit outside the block. Commands enter through a valid/ready pair. `cmd_ready` is high only while no frame is running, and a command is taken in the cycle where both signals are high. A `cmd_valid` seen while `cmd_ready` is low is dropped and does not wait. The result leaves as a right-aligned 16-bit word with a one-cycle `done` strobe. The result has no back-pressure: the word stays on `result` until the next frame completes.

Top module: `adc_sdio_master`

## Requirements
- R1: After reset and whenever no frame is running, `adc_cs_n` is 1, `adc_sck` is 0, `sdio_oe` is 0, `busy` is 0 and `cmd_ready` is 1.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. On the next cycle `adc_cs_n` is 0 and `busy` is 1, and `busy` stays 1 until the cycle in which `done` is 1.
- R3: `adc_sck` has a period of CLK_DIV system clocks (low for the first half, high for the second). Its first rising edge comes CLK_DIV/2 cycles after `adc_cs_n` falls, and each frame has exactly 17 rising edges.
- R4: At rising edges 1 to 5 of `adc_sck`, `sdio_out` carries, in order: 1 (start), `cfg_single`, `cfg_odd_sign`, `cfg_msb_first`, `cfg_shutdown`. These are the values present on the inputs when the command was accepted.
- R5: `sdio_oe` is 1 from the cycle `adc_cs_n` falls through rising edge 5. It drops to 0 three quarters of the way through the fifth clock period, which is after rising edge 5 and before falling edge 5. It stays 0 for the rest of the frame.
- R6: `sdio_in` is sampled at rising edges 6 to 17, giving 12 bits. When `cfg_msb_first` was 1, the first bit sampled is result bit 11.
- R7: When `cfg_msb_first` was 0, the first bit sampled is result bit 0 and the last is bit 11. `result[11:0]` still holds bit 11 down to bit 0.
- R8: After the last rising edge completes its clock period, `done` pulses for one cycle. In that same cycle `adc_cs_n` returns to 1 and `adc_sck` is 0. `result[15:12]` is 0, and `result` changes only in a `done` cycle.
- R9: A `cmd_valid` pulse during a frame has no effect. The running frame's command bits are unchanged, and no second frame or `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller can accept a command (idle) |
| cfg_single | input | 1 | Single-ended (1) or differential (0) select |
| cfg_odd_sign | input | 1 | Channel or polarity select |
| cfg_msb_first | input | 1 | Result order: 1 MSB first, 0 LSB first |
| cfg_shutdown | input | 1 | Converter power-down request bit |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle strobe, result valid |
| result | output | 16 | Right-aligned conversion result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sck | output | 1 | Generated serial clock |
| sdio_out | output | 1 | Value driven onto the shared data pin |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdio_in | input | 1 | Value sampled from the shared data pin |

## Verification
The hardest point to reach is the turnaround. It is not enough that the enable drops at some time: it must drop strictly between the fifth rising and fifth falling serial-clock edges, and only the relative timing of edges seen at the pins shows this. The bench includes a converter model that follows `adc_sck` at every system-clock negedge. The model records the enable at each rising edge and again on the fifth falling edge, and it starts driving the result only after that falling edge. A controller that releases the line early or late therefore either loses a command bit or is seen driving during the converter's slot. A second hard-to-reach case is a command request that lands mid-frame. A forked branch raises `cmd_valid` with different configuration bits while the frame is running.

// File: rtl/adc_sdio_pkg.sv
package adc_sdio_pkg;

  typedef struct packed {
    logic single;
    logic odd_sign;
    logic msb_first;
    logic shutdown;
  } adc_cfg_t;

  localparam int CMD_LEN = 5;

  // bit 0 leaves first: start, single, odd/sign, order, shutdown
  function automatic logic [CMD_LEN-1:0] build_cmd(adc_cfg_t c);
    return {c.shutdown, c.msb_first, c.odd_sign, c.single, 1'b1};
  endfunction

endpackage

// File: rtl/adc_sck_seq.sv
module adc_sck_seq #(
  parameter int CLK_DIV = 8,
  parameter int NPER    = 17,
  localparam int CNT_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int PER_W  = $clog2(NPER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic [PER_W-1:0] per,
  output logic             wrap,
  output logic             last,
  output logic             sck
);
  localparam logic [CNT_W-1:0] TOP_C  = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(CLK_DIV / 2);
  localparam logic [PER_W-1:0] LAST_P = PER_W'(NPER - 1);

  logic [CNT_W-1:0] cnt_n;

  assign wrap  = run && (cnt == TOP_C);
  assign last  = wrap && (per == LAST_P);
  assign cnt_n = (cnt == TOP_C) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
      per <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      sck <= 1'b0;
      if (launch) begin
        run <= 1'b1;
        cnt <= '0;
        per <= '0;
      end
    end else begin
      cnt <= cnt_n;
      sck <= !last && (cnt_n >= HALF_C);
      if (wrap) begin
        if (last) run <= 1'b0;
        else      per <= per + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_cmd_drv.sv
module adc_cmd_drv
  import adc_sdio_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int NPER    = 17,
  localparam int CNT_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int PER_W  = $clog2(NPER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  adc_cfg_t         cfg,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [PER_W-1:0] per,
  input  logic             wrap,
  output logic             dout,
  output logic             oe
);
  localparam int HALF = CLK_DIV / 2;
  // release point: three quarters into the last command period
  localparam logic [CNT_W-1:0] TURN_M1 = CNT_W'(HALF + HALF / 2 - 1);
  localparam logic [PER_W-1:0] CMD_LAST = PER_W'(CMD_LEN - 1);

  logic [CMD_LEN-1:0] cmd_q;
  logic [PER_W-1:0]   per_n;

  assign per_n = per + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      dout  <= 1'b0;
      oe    <= 1'b0;
    end else if (!run) begin
      if (launch) begin
        cmd_q <= build_cmd(cfg);
        dout  <= 1'b1;
        oe    <= 1'b1;
      end else begin
        oe    <= 1'b0;
      end
    end else begin
      if (per == CMD_LAST && cnt == TURN_M1) oe <= 1'b0;
      if (wrap) begin
        if (per_n < PER_W'(CMD_LEN)) dout <= cmd_q[per_n[$clog2(CMD_LEN)-1:0]];
        else                         dout <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_res_cap.sv
module adc_res_cap #(
  parameter int CLK_DIV  = 8,
  parameter int NPER     = 17,
  parameter int RES_BITS = 12,
  parameter int WORD_W   = 16,
  parameter int SKIP     = 5,
  localparam int CNT_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int PER_W   = $clog2(NPER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              msb_first,
  input  logic              run,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [PER_W-1:0]  per,
  input  logic              last,
  input  logic              din,
  output logic [WORD_W-1:0] result,
  output logic              done
);
  localparam logic [CNT_W-1:0] RISE_M1 = CNT_W'(CLK_DIV / 2 - 1);
  localparam logic [PER_W-1:0] FIRST_P = PER_W'(SKIP);

  logic                order_q;
  logic [RES_BITS-1:0] sh;
  logic                take;

  assign take = run && (cnt == RISE_M1) && (per >= FIRST_P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= 1'b1;
      sh      <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch && !run) begin
        order_q <= msb_first;
        sh      <= '0;
      end
      if (take) begin
        if (order_q) sh <= {sh[RES_BITS-2:0], din};
        else         sh <= {din, sh[RES_BITS-1:1]};
      end
      if (last) begin
        result <= WORD_W'(sh);
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_sdio_master.sv
module adc_sdio_master
  import adc_sdio_pkg::*;
#(
  parameter int CLK_DIV  = 8,
  parameter int RES_BITS = 12,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cfg_single,
  input  logic              cfg_odd_sign,
  input  logic              cfg_msb_first,
  input  logic              cfg_shutdown,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic              adc_cs_n,
  output logic              adc_sck,
  output logic              sdio_out,
  output logic              sdio_oe,
  input  logic              sdio_in
);
  localparam int NPER  = CMD_LEN + RES_BITS;
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int PER_W = $clog2(NPER + 1);

  logic             run, wrap, last, launch;
  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] per;
  adc_cfg_t         cfg;

  assign cfg    = '{single: cfg_single, odd_sign: cfg_odd_sign,
                    msb_first: cfg_msb_first, shutdown: cfg_shutdown};
  assign launch = cmd_valid && !run;

  adc_sck_seq #(.CLK_DIV(CLK_DIV), .NPER(NPER)) u_seq (
    .clk, .rst_n, .launch, .run, .cnt, .per, .wrap, .last, .sck(adc_sck)
  );

  adc_cmd_drv #(.CLK_DIV(CLK_DIV), .NPER(NPER)) u_cmd (
    .clk, .rst_n, .launch, .cfg, .run, .cnt, .per, .wrap,
    .dout(sdio_out), .oe(sdio_oe)
  );

  adc_res_cap #(.CLK_DIV(CLK_DIV), .NPER(NPER), .RES_BITS(RES_BITS),
                .WORD_W(WORD_W), .SKIP(CMD_LEN)) u_cap (
    .clk, .rst_n, .launch, .msb_first(cfg_msb_first), .run, .cnt, .per,
    .last, .din(sdio_in), .result, .done
  );

  assign busy      = run;
  assign cmd_ready = !run;
  assign adc_cs_n  = !run;
endmodule

// File: rtl/adc_sdio_chk.sv
module adc_sdio_chk #(
  parameter int CLK_DIV = 8,
  parameter int WORD_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] result,
  input logic              adc_cs_n,
  input logic              adc_sck,
  input logic              sdio_oe
);
  logic [4:0] rises;
  logic       sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_d <= adc_sck;
      if (adc_cs_n)               rises <= '0;
      else if (adc_sck && !sck_d) rises <= rises + 1'b1;
    end
  end

  initial begin
    a_div_legal: assert (CLK_DIV >= 4 && CLK_DIV % 2 == 0);
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (adc_cs_n && !adc_sck && !sdio_oe));

  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !adc_cs_n));

  p_sck_framed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sck);

  p_oe_on_cmd_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sck && !sck_d && rises < 5'd5) |-> sdio_oe);

  p_oe_off_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sck && !sck_d && rises >= 5'd5) |-> !sdio_oe);

  p_done_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (adc_cs_n && !adc_sck && $past(!adc_cs_n)));

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[WORD_W-1:12] == '0));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
endmodule

bind adc_sdio_master adc_sdio_chk #(.CLK_DIV(CLK_DIV), .WORD_W(WORD_W)) u_chk (
  .clk, .rst_n, .cmd_valid, .cmd_ready, .busy, .done, .result,
  .adc_cs_n, .adc_sck, .sdio_oe
);

// File: tb/tb_adc_sdio_master.sv
module tb_adc_sdio_master;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cfg_single = 1'b0, cfg_odd_sign = 1'b0, cfg_msb_first = 1'b1, cfg_shutdown = 1'b0;
  logic busy, done, cmd_ready, adc_cs_n, adc_sck, sdio_out, sdio_oe;
  logic sdio_in = 1'b0;
  logic [15:0] result;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  adc_sdio_master #(.CLK_DIV(DIV)) dut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cfg_single, .cfg_odd_sign,
    .cfg_msb_first, .cfg_shutdown, .busy, .done, .result, .adc_cs_n,
    .adc_sck, .sdio_out, .sdio_oe, .sdio_in
  );

  // converter model and pin monitor, evaluated at negedge
  logic [11:0] adc_val = '0;
  logic        adc_msbf = 1'b1;
  int rise_n = 0, fall_n = 0, since_cs = 0, last_rise = 0, done_n = 0;
  logic [4:0] got_cmd = '0;
  int oe_bad = 0, per_bad = 0, first_rise_at = -1, busy_bad = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  always @(negedge clk) begin
    if (done) done_n <= done_n + 1;
    if (!adc_cs_n && prev_cs) begin
      rise_n = 0; fall_n = 0; since_cs = 0; got_cmd = '0;
    end else if (!adc_cs_n) since_cs = since_cs + 1;
    if (!adc_cs_n && !busy) busy_bad = busy_bad + 1;
    if (adc_sck && !prev_sck) begin
      rise_n = rise_n + 1;
      if (rise_n == 1) first_rise_at = since_cs;
      else if (since_cs - last_rise != DIV) per_bad = per_bad + 1;
      last_rise = since_cs;
      if (rise_n <= 5) begin
        got_cmd[rise_n-1] = sdio_out;
        if (!sdio_oe) oe_bad = oe_bad + 1;
      end else if (sdio_oe) oe_bad = oe_bad + 1;
    end
    if (!adc_sck && prev_sck && !adc_cs_n) begin
      fall_n = fall_n + 1;
      if (fall_n == 5 && sdio_oe) oe_bad = oe_bad + 1;
      if (fall_n >= 5 && fall_n <= 16)
        sdio_in = adc_msbf ? adc_val[11-(fall_n-5)] : adc_val[fall_n-5];
    end
    prev_sck = adc_sck;
    prev_cs  = adc_cs_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic s, o, m, p, input logic [11:0] val,
                           input bit poke, input string tag);
    int n0, w;
    n0 = done_n;
    adc_val = val; adc_msbf = m;
    oe_bad = 0; per_bad = 0; busy_bad = 0; first_rise_at = -1;
    @(negedge clk);
    cfg_single = s; cfg_odd_sign = o; cfg_msb_first = m; cfg_shutdown = p;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!adc_cs_n && busy && !cmd_ready, {"R2 ", tag}, {adc_cs_n, busy}, 2'b01);
    fork
      if (poke) begin
        repeat (3 * DIV) @(negedge clk);
        cfg_single = ~s; cfg_odd_sign = ~o; cfg_msb_first = ~m; cfg_shutdown = ~p;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join_none
    w = 0;
    while (!done && w < 40 * DIV) begin @(negedge clk); w++; end
    check(done === 1'b1, {"R8 done ", tag}, done, 1);
    check(adc_cs_n && !adc_sck, {"R8 cs/sck at done ", tag}, {adc_cs_n, adc_sck}, 2'b10);
    check(result == {4'h0, val}, m ? {"R6 ", tag} : {"R7 ", tag}, result, {4'h0, val});
    check(got_cmd == {p, m, o, s, 1'b1}, {"R4 ", tag}, got_cmd, {p, m, o, s, 1'b1});
    check(oe_bad == 0, {"R5 ", tag}, oe_bad, 0);
    check(rise_n == 17 && per_bad == 0 && first_rise_at == HALF,
          {"R3 ", tag}, rise_n, 17);
    check(busy_bad == 0, {"R2 busy ", tag}, busy_bad, 0);
    @(negedge clk);
    check(!done && !busy && cmd_ready, {"R1 idle ", tag}, {done, busy}, 0);
    check(done_n == n0 + 1, {"R8 one strobe ", tag}, done_n - n0, 1);
  endtask

  task automatic t_reset();
    check(adc_cs_n && !adc_sck && !sdio_oe && !busy && cmd_ready,
          "R1 reset", {adc_cs_n, adc_sck, sdio_oe, busy, cmd_ready}, 5'b10001);
    check(result == 16'h0 && !done, "R1 reset result", result, 0);
  endtask

  task automatic t_msb_first();
    run_frame(1, 0, 1, 0, 12'hABC, 0, "msb abc");
    run_frame(0, 1, 1, 1, 12'hFFF, 0, "msb fff");
    run_frame(1, 1, 1, 0, 12'h000, 0, "msb 000");
    run_frame(0, 0, 1, 1, 12'h801, 0, "msb 801");
  endtask

  task automatic t_lsb_first();
    run_frame(1, 0, 0, 1, 12'h5A3, 0, "lsb 5a3");
    run_frame(0, 1, 0, 0, 12'h001, 0, "lsb 001");
  endtask

  task automatic t_busy_ignore();
    logic [15:0] held;
    run_frame(1, 0, 1, 0, 12'h3C6, 1, "R9 poke");
    held = result;
    repeat (3 * 17 * DIV) @(negedge clk);
    check(adc_cs_n && !busy, "R9 no second frame", busy, 0);
    check(result == held, "R9/R8 result held", result, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_msb_first();
    t_lsb_first();
    t_busy_ignore();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule